// File: doc/BRIEF.md
# Temperature Threshold Alert with Consecutive-Fault Filter

This block watches a stream of signed 16-bit temperature samples (1/128 degree per LSB) and raises an alert when the temperature stays at or above an upper limit for a programmable number of samples in a row. In comparator mode the alert stays up until the temperature has been at or below a lower limit for the same number of samples in a row. In interrupt mode the alert is an event flag. It is raised on a run of upper-limit faults, cleared by any register read or by a sleep-entry pulse, and then armed for a run of lower-limit faults. The two roles keep taking turns after that.

The block holds only the filter and alert state. The limits and configuration bits come from register storage outside the block. The surrounding logic pulses `reg_read` whenever any register is read and pulses `sleep_enter` when the part is put to sleep. The output pin level and the readable status bit are decoded from the state through the polarity setting.

Top module: `temp_alert_filter`

## Requirements
- R1: After reset the alert is inactive, the filter watches the upper limit, and with `cfg_active_high`=0 both `alert_out` and `alert_status` read 1.
- R2: A sample is an upper-limit fault when sample >= `thr_high` and a lower-limit fault when sample <= `thr_low`. Both comparisons are signed two's complement, and equality counts as a fault.
- R3: The required run length is N = `cfg_fault_sel`+1 (00→1, 01→2, 10→3, 11→4). A valid sample that is not a fault of the watched kind resets the run to zero. Cycles without `sample_valid` neither extend nor break a run.
- R4: In comparator mode (`cfg_irq_mode`=0) the alert turns active on the N-th consecutive upper-limit fault and turns inactive on the N-th consecutive lower-limit fault. `alert_status` always equals `alert_out`.
- R5: In interrupt mode (`cfg_irq_mode`=1) the alert turns active on the N-th consecutive fault of the watched kind, and the watched kind then swaps (upper first, then lower, then upper again). A `reg_read` pulse clears the active alert without changing the watched kind.
- R6: In interrupt mode a `sleep_enter` pulse clears the alert. In comparator mode `reg_read` and `sleep_enter` have no effect on either output.
- R7: `alert_out` is the active state when `cfg_active_high`=1 and its inverse when 0. `alert_status` is 0 with polarity 0 (1 with polarity 1) after an upper-limit run has been taken, and the opposite after a lower-limit run has been taken.
- R8: Any change of `cfg_irq_mode` clears the alert, the run count and the watched kind back to the reset state, and the sample presented in that cycle is discarded.
- R9: If a sample completes a run in the same cycle as a clearing `reg_read` or `sleep_enter`, the alert ends that cycle active.
- R10: Outputs reflect a sample in the cycle after the clock edge that accepts it (one register stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | A new temperature sample is present this cycle |
| sample_value | input | 16 | Signed temperature sample, 1/128 degree per LSB |
| thr_high | input | 16 | Signed upper limit |
| thr_low | input | 16 | Signed lower limit |
| cfg_fault_sel | input | 2 | Consecutive-fault count select, N = value + 1 |
| cfg_irq_mode | input | 1 | 0 comparator mode, 1 interrupt mode |
| cfg_active_high | input | 1 | Output polarity, 1 active-high |
| reg_read | input | 1 | Pulse: a register was read |
| sleep_enter | input | 1 | Pulse: sleep mode was entered |
| alert_out | output | 1 | Alert pin level |
| alert_status | output | 1 | Readable alert status bit |

## Verification
Directed runs step samples across both limits at each run length, so that a run cut short by one in-range sample is told apart from a complete run. They also land samples exactly on the limits and on negative values, which separates signed from unsigned comparison and >= from >. Interrupt-mode sequences clear the alert by read and by sleep and then check that only a lower-limit run can raise it again. Long constrained-random stretches cluster samples around the limits while toggling polarity, run length, mode and clear pulses, which exposes wrong priority between a completing run and a clear, and wrong handling of mode switches.

// File: rtl/temp_alert_pkg.sv
package temp_alert_pkg;

    parameter int unsigned TA_SEL_W = 2;
    localparam int unsigned TA_RUN_W = TA_SEL_W + 1;

    typedef struct packed {
        logic                alerted;
        logic                watch_low;
        logic [TA_RUN_W-1:0] run;
        logic                irq_prev;
    } ta_state_t;

    function automatic logic [TA_RUN_W-1:0] run_need(input logic [TA_SEL_W-1:0] sel);
        return TA_RUN_W'(sel) + TA_RUN_W'(1);
    endfunction

endpackage

// File: rtl/ta_compare.sv
module ta_compare #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] hi_lim,
    input  logic [DATA_W-1:0] lo_lim,
    output logic              hi_hit,
    output logic              lo_hit
);
    always_comb begin
        hi_hit = ($signed(sample) >= $signed(hi_lim));
        lo_hit = ($signed(sample) <= $signed(lo_lim));
    end
endmodule

// File: rtl/ta_run_next.sv
module ta_run_next
    import temp_alert_pkg::*;
(
    input  logic [TA_RUN_W-1:0] run_cur,
    input  logic [TA_SEL_W-1:0] sel,
    input  logic                hit,
    output logic [TA_RUN_W-1:0] run_nxt,
    output logic                done
);
    logic [TA_RUN_W-1:0] need;
    logic [TA_RUN_W-1:0] inc;

    always_comb begin
        need    = run_need(sel);
        inc     = run_cur + TA_RUN_W'(1);
        done    = 1'b0;
        run_nxt = '0;
        if (hit) begin
            if (inc >= need) begin
                done    = 1'b1;
                run_nxt = '0;
            end else begin
                run_nxt = inc;
            end
        end
    end
endmodule

// File: rtl/ta_polarity.sv
module ta_polarity (
    input  logic alerted,
    input  logic watch_low,
    input  logic active_high,
    output logic pin,
    output logic status
);
    always_comb begin
        pin    = active_high ? alerted : ~alerted;
        status = active_high ? watch_low : ~watch_low;
    end
endmodule

// File: rtl/temp_alert_filter.sv
module temp_alert_filter
    import temp_alert_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [DATA_W-1:0]   sample_value,
    input  logic [DATA_W-1:0]   thr_high,
    input  logic [DATA_W-1:0]   thr_low,
    input  logic [TA_SEL_W-1:0] cfg_fault_sel,
    input  logic                cfg_irq_mode,
    input  logic                cfg_active_high,
    input  logic                reg_read,
    input  logic                sleep_enter,
    output logic                alert_out,
    output logic                alert_status
);
    ta_state_t state_q, state_d;

    logic                hi_hit, lo_hit, watched_hit;
    logic [TA_RUN_W-1:0] run_nxt;
    logic                run_done;

    ta_compare #(.DATA_W(DATA_W)) u_cmp (
        .sample (sample_value),
        .hi_lim (thr_high),
        .lo_lim (thr_low),
        .hi_hit (hi_hit),
        .lo_hit (lo_hit)
    );

    assign watched_hit = state_q.watch_low ? lo_hit : hi_hit;

    ta_run_next u_run (
        .run_cur (state_q.run),
        .sel     (cfg_fault_sel),
        .hit     (watched_hit),
        .run_nxt (run_nxt),
        .done    (run_done)
    );

    always_comb begin
        state_d          = state_q;
        state_d.irq_prev = cfg_irq_mode;
        if (cfg_irq_mode != state_q.irq_prev) begin
            state_d.alerted   = 1'b0;
            state_d.watch_low = 1'b0;
            state_d.run       = '0;
        end else begin
            if (cfg_irq_mode && (reg_read || sleep_enter)) begin
                state_d.alerted = 1'b0;
            end
            if (sample_valid) begin
                state_d.run = run_nxt;
                if (run_done) begin
                    state_d.watch_low = ~state_q.watch_low;
                    state_d.alerted   = cfg_irq_mode ? 1'b1 : ~state_q.watch_low;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    ta_polarity u_pol (
        .alerted     (state_q.alerted),
        .watch_low   (state_q.watch_low),
        .active_high (cfg_active_high),
        .pin         (alert_out),
        .status      (alert_status)
    );
endmodule

// File: rtl/temp_alert_filter_chk.sv
module temp_alert_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic sample_valid,
    input logic cfg_irq_mode,
    input logic cfg_active_high,
    input logic reg_read,
    input logic sleep_enter,
    input logic alert_out,
    input logic alert_status
);
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_irq_mode && $past(cfg_irq_mode) && reg_read && !sample_valid)
        |=> (alert_out != cfg_active_high)); // R5

    AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_irq_mode && $past(cfg_irq_mode) && sleep_enter && !sample_valid)
        |=> (alert_out != cfg_active_high)); // R6

    AST_CMP_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_irq_mode && !$past(cfg_irq_mode)) |-> (alert_status == alert_out)); // R4

    AST_CMP_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_irq_mode && !$past(cfg_irq_mode) && !sample_valid)
        |=> ($changed(cfg_active_high) || $stable(alert_out))); // R6

    AST_MODE_FLIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_irq_mode != $past(cfg_irq_mode))
        |=> (alert_out != cfg_active_high && alert_status != cfg_active_high)); // R8
endmodule

bind temp_alert_filter temp_alert_filter_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sample_valid    (sample_valid),
    .cfg_irq_mode    (cfg_irq_mode),
    .cfg_active_high (cfg_active_high),
    .reg_read        (reg_read),
    .sleep_enter     (sleep_enter),
    .alert_out       (alert_out),
    .alert_status    (alert_status)
);

// File: tb/tb_temp_alert_filter.sv
module tb_temp_alert_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [15:0] sample_value = '0;
    logic [15:0] thr_high = 16'h2800;
    logic [15:0] thr_low = 16'h2580;
    logic [1:0]  cfg_fault_sel = 2'd0;
    logic        cfg_irq_mode = 1'b0;
    logic        cfg_active_high = 1'b0;
    logic        reg_read = 1'b0;
    logic        sleep_enter = 1'b0;
    logic        alert_out, alert_status;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference state
    bit m_alert = 0;
    bit m_watch = 0;
    int m_run = 0;
    bit m_prev_irq = 0;

    always #2 clk = ~clk;

    temp_alert_filter dut (
        .clk(clk), .rst_n(rst_n),
        .sample_valid(sample_valid), .sample_value(sample_value),
        .thr_high(thr_high), .thr_low(thr_low),
        .cfg_fault_sel(cfg_fault_sel), .cfg_irq_mode(cfg_irq_mode),
        .cfg_active_high(cfg_active_high), .reg_read(reg_read),
        .sleep_enter(sleep_enter),
        .alert_out(alert_out), .alert_status(alert_status)
    );

    function automatic bit exp_pin();
        return cfg_active_high ? m_alert : !m_alert;
    endfunction

    function automatic bit exp_status();
        return cfg_active_high ? m_watch : !m_watch;
    endfunction

    // model update for one accepting edge, from the requirements
    task automatic model_edge();
        bit hit;
        if (cfg_irq_mode != m_prev_irq) begin                 // R8
            m_alert = 0; m_watch = 0; m_run = 0;
        end else begin
            if (cfg_irq_mode && (reg_read || sleep_enter)) m_alert = 0;  // R5 R6
            if (sample_valid) begin
                hit = m_watch ? ($signed(sample_value) <= $signed(thr_low))
                              : ($signed(sample_value) >= $signed(thr_high));   // R2
                if (!hit) m_run = 0;                          // R3
                else if (m_run + 1 >= int'(cfg_fault_sel) + 1) begin
                    m_run = 0;
                    m_watch = !m_watch;
                    m_alert = cfg_irq_mode ? 1'b1 : m_watch;  // R4 R5 R9
                end else m_run = m_run + 1;
            end
        end
        m_prev_irq = cfg_irq_mode;
    endtask

    task automatic check(input string tag);
        total++;
        if (alert_out !== exp_pin() || alert_status !== exp_status()) begin
            bad++;
            $display("FAIL %s: out=%0b status=%0b expected out=%0b status=%0b",
                     tag, alert_out, alert_status, exp_pin(), exp_status());
        end
    endtask

    // drive at negedge, accept at posedge, compare at next negedge (R10)
    task automatic step(input bit v, input logic [15:0] s, input bit rd, input bit sl,
                        input string tag);
        sample_valid = v; sample_value = s; reg_read = rd; sleep_enter = sl;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        sample_valid = 0; reg_read = 0; sleep_enter = 0;
        check(tag);
    endtask

    task automatic samples(input logic [15:0] s, input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, s, 0, 0, tag);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: out=%0b status=%0b expected finish", alert_out, alert_status);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1;
        @(negedge clk);
        check("R1 after release");
        total++;
        if (alert_out !== 1'b1 || alert_status !== 1'b1) begin
            bad++; $display("FAIL R1: out=%0b status=%0b expected 1 1", alert_out, alert_status);
        end

        // R2 R4 equality and signed limits, N=1
        step(1, 16'h27FF, 0, 0, "R2 just below high");
        step(1, 16'h2800, 0, 0, "R2 equal high trips");
        total++;
        if (alert_out !== 1'b0) begin bad++; $display("FAIL R4: out=%0b expected 0", alert_out); end
        step(1, 16'h2581, 0, 0, "R2 just above low");
        step(1, 16'h2580, 0, 0, "R2 equal low clears");

        // negative limits: signed comparison R2
        thr_high = 16'hF380; thr_low = 16'hEC00;
        step(1, 16'h7FFF, 0, 0, "R2 positive above negative high");
        step(1, 16'hEC01, 0, 0, "R2 signed not below low");
        step(1, 16'h8000, 0, 0, "R2 most negative below low");

        // R3 run of 3 interrupted, no-valid cycles neutral
        thr_high = 16'h1900; thr_low = 16'h0C80;
        cfg_fault_sel = 2'b10;
        samples(16'h2000, 2, "R3 two highs");
        step(0, 16'h0000, 0, 0, "R3 idle keeps run");
        step(1, 16'h1000, 0, 0, "R3 break resets run");
        samples(16'h2000, 2, "R3 rebuilt two");
        step(0, 16'h0000, 0, 0, "R3 idle");
        step(1, 16'h2000, 0, 0, "R3 third completes");
        step(1, 16'h0000, 1, 1, "R6 read and sleep ignored in comparator");
        cfg_fault_sel = 2'b11;
        samples(16'h0C80, 4, "R3 four lows clear");

        // R7 polarity flip
        cfg_active_high = 1;
        @(negedge clk); check("R7 polarity high");

        // R5 interrupt mode, R8 mode change
        cfg_fault_sel = 2'b01;
        step(1, 16'h3000, 0, 0, "R8 mode change discards sample");
        cfg_irq_mode = 1;
        step(1, 16'h3000, 0, 0, "R8 switch into interrupt");
        samples(16'h3000, 2, "R5 high run sets");
        step(0, 0, 1, 0, "R5 read clears");
        samples(16'h3000, 3, "R5 highs no longer count");
        samples(16'h0100, 2, "R5 low run sets");
        step(0, 0, 0, 1, "R6 sleep clears");
        step(1, 16'h3000, 0, 0, "R5 high one");
        step(1, 16'h3000, 1, 0, "R9 completing run beats read");
        cfg_active_high = 0;
        @(negedge clk); check("R7 status in interrupt");

        // random
        for (int k = 0; k < 6000; k++) begin
            bit v, rd, sl;
            logic [15:0] s;
            if ($urandom_range(0, 99) < 3) cfg_irq_mode = ~cfg_irq_mode;
            if ($urandom_range(0, 99) < 3) cfg_active_high = ~cfg_active_high;
            if ($urandom_range(0, 99) < 4) cfg_fault_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 999) < 5) begin
                thr_high = 16'($signed(16'($urandom_range(0, 800))) - 16'sd200);
                thr_low  = 16'($signed(thr_high) - 16'($urandom_range(0, 300)));
            end
            v  = ($urandom_range(0, 99) < 70);
            rd = ($urandom_range(0, 99) < 8);
            sl = ($urandom_range(0, 99) < 3);
            case ($urandom_range(0, 3))
                0: s = thr_high;
                1: s = thr_low;
                2: s = 16'($signed(thr_high) + 16'($urandom_range(0, 40)) - 16'sd20);
                default: s = 16'($signed(thr_low) + 16'($urandom_range(0, 40)) - 16'sd20);
            endcase
            step(v, s, rd, sl, "R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule